// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single words between two independently clocked ports, alongside the main data queues and independent of them. Two mailbox registers sit side by side. The first carries a word from the A side to the B side, and the second carries a word from the B side to the A side. Each mailbox has an active-LOW full flag. The writing side sees this flag in its own clock domain. A write drops the flag on the writer's clock edge. Once the flag is LOW, further writes to that mailbox are locked out. The flag rises again only after the other side has read the word, and this read is seen through a two-flop toggle synchronizer.

Each port has a direction input and a mailbox select. On a read, each port loads an output register that holds either the mailbox word from the opposite side or the output-register word of the queue that feeds that port. Each port also registers an output-enable for its tri-state pads. The two ports use opposite direction polarities. On port A, a HIGH direction input means write. On port B, a LOW direction input means write. Each queue reset returns its mailbox to empty and clears the output register of the port that reads from it.

Top module: `dual_mailbox`

## Requirements
- R1: While a reset is held, the output register of the port that it feeds reads zero and the full flag of its mailbox reads HIGH. `q1_rst` clears `b_dout` and returns `a2b_full_n` HIGH. `q2_rst` clears `a_dout` and returns `b2a_full_n` HIGH.
- R2: A `clk_a` rising edge with `a_dir`=1 (write), `a_mbsel`=1 and `a2b_full_n`=1 stores `a_din` in the A-to-B mailbox. `a2b_full_n` reads LOW directly after that edge.
- R3: While `a2b_full_n` is LOW, A-side mailbox writes are ignored. The stored word and the flag do not change.
- R4: A `clk_b` rising edge with `b_dir`=1 (read) and `b_mbsel`=1, on which the B side sees the A-to-B mailbox as full, empties it. `a2b_full_n` returns HIGH within four `clk_a` cycles.
- R5: A B-side mailbox read loads the A-to-B mailbox word into `b_dout` on that same `clk_b` edge.
- R6: The B-to-A mailbox behaves in the same way with the ports exchanged. A B write (`b_dir`=0, `b_mbsel`=1) drops `b2a_full_n`. Further B writes are ignored while it is LOW. An A read (`a_dir`=0, `a_mbsel`=1) loads the word into `a_dout` and returns `b2a_full_n` HIGH within four `clk_b` cycles.
- R7: A read with the mailbox select LOW loads the queue output word (`a_fifo_q` on A, `b_fifo_q` on B) into the output register.
- R8: `a_oe` equals the inverse of `a_dir` and `b_oe` equals `b_dir`, each registered on its port clock. `dout` holds its value while its port is writing.
- R9: A reset of one queue leaves the other mailbox and its flag untouched.
- R10: A mailbox read while the reader sees the mailbox empty has no effect. The next write still drops the flag, and the flag stays LOW until a real read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| q1_rst | input | 1 | Reset of the A-to-B queue, active HIGH, held at least four cycles of each clock |
| q2_rst | input | 1 | Reset of the B-to-A queue, active HIGH, held at least four cycles of each clock |
| a_dir | input | 1 | Port A direction: 1 write, 0 read |
| a_mbsel | input | 1 | Port A mailbox select |
| a_din | input | DATA_W | Port A write data |
| a_fifo_q | input | DATA_W | Output register word of the queue read at port A |
| a_dout | output | DATA_W | Port A output register |
| a_oe | output | 1 | Port A pad drive enable |
| a2b_full_n | output | 1 | A-to-B mailbox full flag, active LOW, in `clk_a` domain |
| b_dir | input | 1 | Port B direction: 0 write, 1 read |
| b_mbsel | input | 1 | Port B mailbox select |
| b_din | input | DATA_W | Port B write data |
| b_fifo_q | input | DATA_W | Output register word of the queue read at port B |
| b_dout | output | DATA_W | Port B output register |
| b_oe | output | 1 | Port B pad drive enable |
| b2a_full_n | output | 1 | B-to-A mailbox full flag, active LOW, in `clk_b` domain |

## Verification
The bench writes a second word into a full mailbox. A design that ignores the lockout would overwrite the first word, and the reader would receive the wrong value. It reads an empty mailbox before a write. A reader side that toggles its acknowledge on that read would leave the following write unflagged, or would free the mailbox at once. It resets one queue while both mailboxes hold words. Crossed resets would empty the wrong mailbox or leave a stale word on the B outputs. It also drives the opposite direction polarities of the two ports. A swapped decode would turn reads into writes and invert the enables.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic {
    MB_WRITE = 1'b0,
    MB_READ  = 1'b1
  } mb_dir_e;

  localparam int unsigned MB_SYNC_MIN = 2;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain = {STAGES{INIT}};

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{INIT}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              wrst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wdata,
  output logic              wfree,
  input  logic              rclk,
  input  logic              rrst,
  input  logic              rd_req,
  output logic              rfull,
  output logic [DATA_W-1:0] mail
);
  logic wr_tog, rd_tog, rd_tog_w, wr_tog_r;

  // writer side: toggle marks a new word, data captured on the same edge
  always_ff @(posedge wclk) begin
    if (wrst) begin
      wr_tog <= 1'b0;
      mail   <= '0;
    end else if (wr_req && wfree) begin
      wr_tog <= ~wr_tog;
      mail   <= wdata;
    end
  end

  // reader side: toggle acknowledges only a word it can see
  always_ff @(posedge rclk) begin
    if (rrst)                 rd_tog <= 1'b0;
    else if (rd_req && rfull) rd_tog <= ~rd_tog;
  end

  mbox_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_ack_sync (
    .clk(wclk), .rst(wrst), .d(rd_tog), .q(rd_tog_w)
  );
  mbox_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_req_sync (
    .clk(rclk), .rst(rrst), .d(wr_tog), .q(wr_tog_r)
  );

  assign wfree = (wr_tog == rd_tog_w);
  assign rfull = (wr_tog_r != rd_tog);

  // R3: a locked mailbox keeps its word
  a_r3_locked_word: assert property (@(posedge wclk) disable iff (wrst)
    !wfree |=> $stable(mail));
  // R4: a read of a visible word leaves the reader seeing it empty
  a_r4_read_empties: assert property (@(posedge rclk) disable iff (rrst)
    (rd_req && rfull) |=> !rfull);
  // R10: the acknowledge never moves while the reader sees it empty
  a_r10_empty_read: assert property (@(posedge rclk) disable iff (rrst)
    !rfull |=> $stable(rd_tog));
endmodule

// File: rtl/mbox_port.sv
module mbox_port #(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_mode,
  input  logic              mbsel,
  input  logic [DATA_W-1:0] mail,
  input  logic [DATA_W-1:0] fifo_q,
  output logic [DATA_W-1:0] dout,
  output logic              oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      oe   <= 1'b0;
    end else begin
      oe <= rd_mode;
      if (rd_mode) dout <= mbsel ? mail : fifo_q;
    end
  end

  // R7: a queue read shows the queue word one edge later
  a_r7_queue_path: assert property (@(posedge clk) disable iff (rst)
    (rd_mode && !mbsel) |=> dout == $past(fifo_q));
  // R8: output register holds while the port writes
  a_r8_hold_on_write: assert property (@(posedge clk) disable iff (rst)
    !rd_mode |=> $stable(dout));
endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              q1_rst,
  input  logic              q2_rst,
  input  logic              a_dir,
  input  logic              a_mbsel,
  input  logic [DATA_W-1:0] a_din,
  input  logic [DATA_W-1:0] a_fifo_q,
  output logic [DATA_W-1:0] a_dout,
  output logic              a_oe,
  output logic              a2b_full_n,
  input  logic              b_dir,
  input  logic              b_mbsel,
  input  logic [DATA_W-1:0] b_din,
  input  logic [DATA_W-1:0] b_fifo_q,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_oe,
  output logic              b2a_full_n
);
  localparam int unsigned SYNC_N = (SYNC_STAGES < MB_SYNC_MIN) ? MB_SYNC_MIN : SYNC_STAGES;
  localparam int unsigned RST_N  = (RST_STAGES  < MB_SYNC_MIN) ? MB_SYNC_MIN : RST_STAGES;

  logic rst1_a, rst1_b, rst2_a, rst2_b;
  mb_dir_e a_mode, b_mode;
  logic a_mb_wr, a_mb_rd, b_mb_wr, b_mb_rd;
  logic a2b_free, a2b_full_r, b2a_free, b2a_full_r;
  logic [DATA_W-1:0] a2b_word, b2a_word;

  // per-domain reset synchronizers, asserted from power-up
  mbox_sync #(.STAGES(RST_N), .INIT(1'b1)) u_r1a (.clk(clk_a), .rst(1'b0), .d(q1_rst), .q(rst1_a));
  mbox_sync #(.STAGES(RST_N), .INIT(1'b1)) u_r1b (.clk(clk_b), .rst(1'b0), .d(q1_rst), .q(rst1_b));
  mbox_sync #(.STAGES(RST_N), .INIT(1'b1)) u_r2a (.clk(clk_a), .rst(1'b0), .d(q2_rst), .q(rst2_a));
  mbox_sync #(.STAGES(RST_N), .INIT(1'b1)) u_r2b (.clk(clk_b), .rst(1'b0), .d(q2_rst), .q(rst2_b));

  // direction decode: opposite polarities on the two ports
  assign a_mode  = a_dir ? MB_WRITE : MB_READ;
  assign b_mode  = b_dir ? MB_READ  : MB_WRITE;
  assign a_mb_wr = (a_mode == MB_WRITE) && a_mbsel;
  assign a_mb_rd = (a_mode == MB_READ)  && a_mbsel;
  assign b_mb_wr = (b_mode == MB_WRITE) && b_mbsel;
  assign b_mb_rd = (b_mode == MB_READ)  && b_mbsel;

  mbox_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_N)) u_a2b (
    .wclk(clk_a), .wrst(rst1_a), .wr_req(a_mb_wr), .wdata(a_din), .wfree(a2b_free),
    .rclk(clk_b), .rrst(rst1_b), .rd_req(b_mb_rd), .rfull(a2b_full_r), .mail(a2b_word)
  );
  mbox_channel #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_N)) u_b2a (
    .wclk(clk_b), .wrst(rst2_b), .wr_req(b_mb_wr), .wdata(b_din), .wfree(b2a_free),
    .rclk(clk_a), .rrst(rst2_a), .rd_req(a_mb_rd), .rfull(b2a_full_r), .mail(b2a_word)
  );

  assign a2b_full_n = a2b_free;
  assign b2a_full_n = b2a_free;

  mbox_port #(.DATA_W(DATA_W)) u_port_a (
    .clk(clk_a), .rst(rst2_a), .rd_mode(a_mode == MB_READ), .mbsel(a_mbsel),
    .mail(b2a_word), .fifo_q(a_fifo_q), .dout(a_dout), .oe(a_oe)
  );
  mbox_port #(.DATA_W(DATA_W)) u_port_b (
    .clk(clk_b), .rst(rst1_b), .rd_mode(b_mode == MB_READ), .mbsel(b_mbsel),
    .mail(a2b_word), .fifo_q(b_fifo_q), .dout(b_dout), .oe(b_oe)
  );

  // R1: reset clears the output register fed by that queue
  a_r1_b_out_reset: assert property (@(posedge clk_b) rst1_b |=> b_dout == '0);
  a_r1_a_out_reset: assert property (@(posedge clk_a) rst2_a |=> a_dout == '0);
  // R2: a granted A write drops the flag on that edge
  a_r2_a_write_flag: assert property (@(posedge clk_a) disable iff (rst1_a)
    (a_mb_wr && a2b_full_n) |=> !a2b_full_n);
  // R6: a granted B write drops the flag on that edge
  a_r6_b_write_flag: assert property (@(posedge clk_b) disable iff (rst2_b)
    (b_mb_wr && b2a_full_n) |=> !b2a_full_n);
  // R8: enables follow the direction inputs by one edge
  a_r8_a_enable: assert property (@(posedge clk_a) disable iff (rst2_a)
    a_dir |=> !a_oe);
  a_r8_b_enable: assert property (@(posedge clk_b) disable iff (rst1_b)
    !b_dir |=> !b_oe);
endmodule

// File: tb/dual_mailbox_tb_top.sv
module dual_mailbox_tb_top;
  localparam int W = 36;

  logic clk_a = 1'b0, clk_b = 1'b0;
  always #10 clk_a = ~clk_a;
  always #13 clk_b = ~clk_b;

  logic q1_rst = 1'b1, q2_rst = 1'b1;
  logic a_dir = 1'b0, a_mbsel = 1'b0, b_dir = 1'b0, b_mbsel = 1'b0;
  logic [W-1:0] a_din = '0, a_fifo_q = '0, b_din = '0, b_fifo_q = '0;
  logic [W-1:0] a_dout, b_dout;
  logic a_oe, b_oe, a2b_full_n, b2a_full_n;

  dual_mailbox #(.DATA_W(W)) dut_i (
    .clk_a(clk_a), .clk_b(clk_b), .q1_rst(q1_rst), .q2_rst(q2_rst),
    .a_dir(a_dir), .a_mbsel(a_mbsel), .a_din(a_din), .a_fifo_q(a_fifo_q),
    .a_dout(a_dout), .a_oe(a_oe), .a2b_full_n(a2b_full_n),
    .b_dir(b_dir), .b_mbsel(b_mbsel), .b_din(b_din), .b_fifo_q(b_fifo_q),
    .b_dout(b_dout), .b_oe(b_oe), .b2a_full_n(b2a_full_n)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [W-1:0] sb_a2b[$], sb_b2a[$];
  bit m_a2b_free = 1'b1, m_b2a_free = 1'b1;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic a_wait(input int n); repeat (n) @(negedge clk_a); endtask
  task automatic b_wait(input int n); repeat (n) @(negedge clk_b); endtask

  // drivers: push the expected word when the model says the mailbox is free
  task automatic a_put(input logic [W-1:0] d);
    @(negedge clk_a);
    a_dir = 1'b1; a_mbsel = 1'b1; a_din = d;
    if (m_a2b_free) begin sb_a2b.push_back(d); m_a2b_free = 1'b0; end
    @(negedge clk_a);
    a_dir = 1'b0; a_mbsel = 1'b0;
  endtask

  task automatic b_put(input logic [W-1:0] d);
    @(negedge clk_b);
    b_dir = 1'b0; b_mbsel = 1'b1; b_din = d;
    if (m_b2a_free) begin sb_b2a.push_back(d); m_b2a_free = 1'b0; end
    @(negedge clk_b);
    b_mbsel = 1'b0;
  endtask

  // monitors: pop the expected word and compare the read result
  task automatic b_take(input string req);
    b_wait(3);
    b_dir = 1'b1; b_mbsel = 1'b1;
    @(negedge clk_b);
    if (sb_a2b.size() > 0) begin
      check(req, b_dout, sb_a2b.pop_front());
      m_a2b_free = 1'b1;
    end
    b_dir = 1'b0; b_mbsel = 1'b0;
  endtask

  task automatic a_take(input string req);
    a_wait(3);
    a_dir = 1'b0; a_mbsel = 1'b1;
    @(negedge clk_a);
    if (sb_b2a.size() > 0) begin
      check(req, a_dout, sb_b2a.pop_front());
      m_b2a_free = 1'b1;
    end
    a_mbsel = 1'b0;
  endtask

  initial begin
    #(20 * 60000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset held with nonzero queue words on read ports
    a_fifo_q = 36'h5A5A5A5A5; b_fifo_q = 36'hA5A5A5A5A;
    b_dir = 1'b1;
    b_wait(8);
    check("R1 a_dout in reset", a_dout, '0);
    check("R1 b_dout in reset", b_dout, '0);
    check("R1 a2b flag in reset", {35'd0, a2b_full_n}, 36'd1);
    check("R1 b2a flag in reset", {35'd0, b2a_full_n}, 36'd1);
    q1_rst = 1'b0; q2_rst = 1'b0; b_dir = 1'b0;
    b_wait(6);

    // R2: first write drops flag
    a_put(36'h123456789);
    check("R2 a2b flag after write", {35'd0, a2b_full_n}, 36'd0);
    // R3: second write ignored
    a_put(36'h0BADC0DE0);
    check("R3 a2b flag after blocked write", {35'd0, a2b_full_n}, 36'd0);
    // R5: reader gets the first word
    b_take("R5 R3 b mailbox read word");
    a_wait(4);
    check("R4 a2b flag after read", {35'd0, a2b_full_n}, 36'd1);

    // R6: reverse direction
    b_put(36'hFEDCBA987);
    check("R6 b2a flag after write", {35'd0, b2a_full_n}, 36'd0);
    b_put(36'h111111111);
    check("R6 b2a flag after blocked write", {35'd0, b2a_full_n}, 36'd0);
    a_take("R6 a mailbox read word");
    b_wait(4);
    check("R6 b2a flag after read", {35'd0, b2a_full_n}, 36'd1);

    // R7 / R8: queue path, enables and hold
    a_fifo_q = 36'h0CAFEF00D;
    a_wait(2);
    check("R7 a queue word", a_dout, 36'h0CAFEF00D);
    check("R8 a_oe when reading", {35'd0, a_oe}, 36'd1);
    b_fifo_q = 36'h777000777;
    b_dir = 1'b1;
    b_wait(2);
    check("R7 b queue word", b_dout, 36'h777000777);
    check("R8 b_oe when reading", {35'd0, b_oe}, 36'd1);
    b_dir = 1'b0; b_fifo_q = 36'h000000001;
    b_wait(2);
    check("R8 b_oe when writing", {35'd0, b_oe}, 36'd0);
    check("R8 b_dout holds when writing", b_dout, 36'h777000777);
    a_dir = 1'b1;
    a_wait(2);
    check("R8 a_oe when writing", {35'd0, a_oe}, 36'd0);
    a_dir = 1'b0;

    // R10: read of an empty mailbox has no effect
    b_take("R10 empty read");
    a_wait(4);
    a_put(36'h246802468);
    check("R10 flag drops after empty read", {35'd0, a2b_full_n}, 36'd0);
    a_wait(6);
    check("R10 flag stays low", {35'd0, a2b_full_n}, 36'd0);
    b_take("R10 R5 word after empty read");
    a_wait(4);
    check("R10 flag high after real read", {35'd0, a2b_full_n}, 36'd1);

    // R9: reset of one queue only
    a_put(36'h0AAAA5555);
    b_put(36'h055550AAA);
    b_dir = 1'b1;
    b_wait(1);
    b_dir = 1'b0;
    q1_rst = 1'b1;
    b_wait(8);
    q1_rst = 1'b0;
    b_wait(6);
    sb_a2b.delete(); m_a2b_free = 1'b1;
    check("R9 R1 a2b flag after q1 reset", {35'd0, a2b_full_n}, 36'd1);
    check("R9 b2a flag kept", {35'd0, b2a_full_n}, 36'd0);
    check("R1 b_dout cleared by q1 reset", b_dout, '0);
    a_take("R9 b2a word kept");
    b_wait(4);
    check("R9 b2a flag after read", {35'd0, b2a_full_n}, 36'd1);
    a_put(36'h135713571);
    check("R2 write after q1 reset", {35'd0, a2b_full_n}, 36'd0);
    b_take("R5 word after q1 reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule